// File: doc/BRIEF.md
# Bit-Reversed Strided Load Address Unit

This block produces memory addresses for a vector of scalar loads. The element offsets follow bit-reversed index order, which is the access pattern of radix-2 FFT stages. For each element step the caller hands over five things: the step index, the vector length, the base register value, a signed displacement and a shift amount. The block forms `base + ((bitrev(step) * displacement) << shift)` in 64-bit arithmetic and issues one memory request. It then formats the returned data by access size and signedness. For update forms it also returns the address as a write-back value for the base register.

Only one element is in flight at a time. The element input, the memory request and the result output each use a valid/ready handshake. `in_ready` is high only while the unit is idle. A raised `mem_req_valid` stays high, with address and size frozen, until `mem_req_ready` is seen high at a clock edge. A raised `out_valid` stays high, with all result fields frozen, until `out_ready` is seen. No new element is accepted until the result has been consumed. The memory response side has no back-pressure. `mem_rsp_valid` is taken only while a response is awaited.

The low six bits of the shift-source register are supplied on `in_shamt`. The register file, the memory system and instruction decode are outside this block.

Top module: `brld_agu_top`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `mem_req_valid` and `out_valid` are 0. An element is taken on a clock edge where `in_valid` and `in_ready` are both 1, and `mem_req_valid` is 1 after that edge.
- R2: `mem_req_addr` equals (base + ((rev * D) << `in_shamt`)) mod 2^64. Here rev is the bit-reversed step index, zero-extended, and D is the displacement below. Address and size hold steady while `mem_req_valid` is 1 and `mem_req_ready` is 0, and `mem_req_valid` falls after the accepting edge.
- R3: When `in_vl` = 2^k, rev reverses the low k bits of `in_step`, and the higher step bits are ignored. When `in_vl` is 1, rev is 0.
- R4: For a non-update element whose `in_ra_idx` is 0, the base is zero and `in_base` is ignored.
- R5: For an update element, `in_base` is always used. When the form is valid, `out_wb_valid` is 1 and `out_wb_data` equals the issued address.
- R6: Kinds 4, 5, 6 and 7 use D = sign-extend({`in_disp`[13:0], 2'b00}). Kinds 0 to 3 use D = sign-extend(`in_disp`[15:0]).
- R7: The kind codes are: 0 byte zero-extended, 1 halfword zero-extended, 2 halfword sign-extended, 3 word zero-extended, 4 word sign-extended, 5 doubleword, and 6 and 7 act as doubleword. `mem_req_size` is log2 of the byte count: 0, 1, 1, 2, 2, 3, 3, 3.
- R8: For kinds 0, 1 and 3, `out_data` holds the low 1, 2 or 4 bytes of `mem_rsp_data`, and all higher bits are cleared.
- R9: Kinds 2 and 4 sign-extend the low 2 or 4 response bytes to 64 bits. Kinds 5 to 7 pass all 64 bits through unchanged.
- R10: An update element whose `in_ra_idx` is 0, or equals `in_rt_idx`, gives `out_invalid` = 1 and `out_wb_valid` = 0. The load is still performed.
- R11: `out_valid` and every result field hold while `out_ready` is 0. `in_ready` stays 0 from acceptance until the result has been consumed.
- R12: `mem_rsp_valid` is ignored unless a response is awaited. `out_valid` rises only on the edge after a response that was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element step offered |
| in_ready | output | 1 | Unit idle, element can be taken |
| in_step | input | 6 | Element step index |
| in_vl | input | 7 | Vector length, a power of two from 1 to 64 |
| in_base | input | 64 | Base register contents |
| in_ra_idx | input | 5 | Base register number |
| in_rt_idx | input | 5 | Destination register number |
| in_disp | input | 16 | Immediate displacement field |
| in_shamt | input | 6 | Low six bits of the shift-source register |
| in_kind | input | 3 | Load kind code (R7) |
| in_update | input | 1 | Update form, base written back |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Effective address |
| mem_req_size | output | 2 | log2 of access bytes |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Response bytes, right-aligned |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_data | output | 64 | Formatted load value |
| out_wb_valid | output | 1 | Base write-back requested |
| out_wb_data | output | 64 | Base write-back value |
| out_invalid | output | 1 | Update form with illegal register choice |

## Verification
The bench targets the bit-reversal edges:
- A vector length of 1 must yield offset zero. A design that reverses a fixed width would produce a large offset.
- Step values with high bits set must lose those bits under short vector lengths.

It drives displacement fields with set bits 14 and 15 on the scaled kinds. A unit that forgot the two appended zeros or sign-extended from the wrong bit would issue an address off by a factor of four or a sign.

Other cases use register number zero and a base equal to the destination, paired with update and non-update forms. A wrong base-zero rule shows as a shifted address, and a missed illegal form shows as an asserted write-back. A spurious response is pulsed while the request is still stalled; a unit that did not gate it would finish early with the wrong data.

// File: rtl/brld_pkg.sv
package brld_pkg;

  typedef enum logic [2:0] {
    LK_BYTE_Z  = 3'd0,
    LK_HALF_Z  = 3'd1,
    LK_HALF_S  = 3'd2,
    LK_WORD_Z  = 3'd3,
    LK_WORD_S  = 3'd4,
    LK_DWORD   = 3'd5,
    LK_DWORD_6 = 3'd6,
    LK_DWORD_7 = 3'd7
  } load_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_OUT  = 2'd3
  } agu_state_e;

  // response tag kept with the element until the data returns
  typedef struct packed {
    logic [1:0] size_log;
    logic       sign_ext;
  } rsp_tag_t;

  function automatic logic [1:0] kind_size_log(load_kind_e k);
    case (k)
      LK_BYTE_Z:            return 2'd0;
      LK_HALF_Z, LK_HALF_S: return 2'd1;
      LK_WORD_Z, LK_WORD_S: return 2'd2;
      default:              return 2'd3;
    endcase
  endfunction

  function automatic logic kind_signed(load_kind_e k);
    return (k == LK_HALF_S) || (k == LK_WORD_S);
  endfunction

  // kinds whose displacement is scaled by four
  function automatic logic kind_scaled_disp(load_kind_e k);
    return (k == LK_WORD_S) || (k == LK_DWORD) ||
           (k == LK_DWORD_6) || (k == LK_DWORD_7);
  endfunction

endpackage

// File: rtl/brld_bitrev.sv
module brld_bitrev #(
  parameter int IDXW = 6
) (
  input  logic [IDXW-1:0] step,
  input  logic [IDXW:0]   vl,
  output logic [IDXW-1:0] rev
);
  localparam int KW = $clog2(IDXW + 1);

  logic [IDXW-1:0] cand [IDXW+1];
  logic [KW-1:0]   k;

  // one candidate per reversal width
  for (genvar w = 0; w <= IDXW; w++) begin : g_width
    for (genvar b = 0; b < IDXW; b++) begin : g_bit
      if (b < w) begin : g_in
        assign cand[w][b] = step[w-1-b];
      end else begin : g_zero
        assign cand[w][b] = 1'b0;
      end
    end
  end

  // width = index of the highest set bit of the vector length
  always_comb begin
    k = '0;
    for (int i = 0; i <= IDXW; i++) begin
      if (vl[i]) k = KW'(i);
    end
  end

  assign rev = cand[k];
endmodule

// File: rtl/brld_ea_calc.sv
module brld_ea_calc #(
  parameter int XLEN  = 64,
  parameter int DISPW = 16,
  parameter int IDXW  = 6
) (
  input  logic [XLEN-1:0]         base,
  input  logic                    base_zero,
  input  logic [IDXW-1:0]         rev,
  input  logic [DISPW-1:0]        disp,
  input  logic                    scaled,
  input  logic [$clog2(XLEN)-1:0] shamt,
  output logic [XLEN-1:0]         ea
);
  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] rev_ext;
  logic [XLEN-1:0] prod;
  logic [XLEN-1:0] offs;
  logic [XLEN-1:0] base_eff;

  always_comb begin
    if (scaled)
      disp_ext = {{(XLEN-DISPW){disp[DISPW-3]}}, disp[DISPW-3:0], 2'b00};
    else
      disp_ext = {{(XLEN-DISPW){disp[DISPW-1]}}, disp};
  end

  assign rev_ext  = {{(XLEN-IDXW){1'b0}}, rev};
  assign prod     = rev_ext * disp_ext;
  assign offs     = prod << shamt;
  assign base_eff = base_zero ? '0 : base;
  assign ea       = base_eff + offs;
endmodule

// File: rtl/brld_data_fmt.sv
module brld_data_fmt #(
  parameter int XLEN = 64
) (
  input  brld_pkg::rsp_tag_t tag,
  input  logic [XLEN-1:0]    raw,
  output logic [XLEN-1:0]    val
);
  always_comb begin
    case (tag.size_log)
      2'd0: val = {{(XLEN-8){1'b0}}, raw[7:0]};
      2'd1: val = {{(XLEN-16){tag.sign_ext & raw[15]}}, raw[15:0]};
      2'd2: val = {{(XLEN-32){tag.sign_ext & raw[31]}}, raw[31:0]};
      default: val = raw;
    endcase
  end
endmodule

// File: rtl/brld_agu_top.sv
module brld_agu_top
  import brld_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int DISPW = 16,
  parameter int IDXW  = 6,
  parameter int REGW  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [IDXW-1:0]         in_step,
  input  logic [IDXW:0]           in_vl,
  input  logic [XLEN-1:0]         in_base,
  input  logic [REGW-1:0]         in_ra_idx,
  input  logic [REGW-1:0]         in_rt_idx,
  input  logic [DISPW-1:0]        in_disp,
  input  logic [$clog2(XLEN)-1:0] in_shamt,
  input  logic [2:0]              in_kind,
  input  logic                    in_update,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [XLEN-1:0]         mem_req_addr,
  output logic [1:0]              mem_req_size,
  input  logic                    mem_rsp_valid,
  input  logic [XLEN-1:0]         mem_rsp_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [XLEN-1:0]         out_data,
  output logic                    out_wb_valid,
  output logic [XLEN-1:0]         out_wb_data,
  output logic                    out_invalid
);
  agu_state_e      state_q;
  load_kind_e      kind;
  logic [IDXW-1:0] rev;
  logic [XLEN-1:0] ea;
  logic [XLEN-1:0] fmt_val;
  logic            ra_is_zero;
  logic            bad_form;
  logic            accept;
  rsp_tag_t        tag_d, tag_q;
  logic [XLEN-1:0] addr_q;
  logic [XLEN-1:0] data_q;
  logic            wb_en_q;
  logic            inv_q;

  assign kind       = load_kind_e'(in_kind);
  assign ra_is_zero = (in_ra_idx == '0);
  assign bad_form   = ra_is_zero || (in_ra_idx == in_rt_idx);
  assign accept     = in_valid && in_ready;

  assign tag_d.size_log = kind_size_log(kind);
  assign tag_d.sign_ext = kind_signed(kind);

  brld_bitrev #(.IDXW(IDXW)) u_rev (
    .step (in_step),
    .vl   (in_vl),
    .rev  (rev)
  );

  brld_ea_calc #(.XLEN(XLEN), .DISPW(DISPW), .IDXW(IDXW)) u_ea (
    .base      (in_base),
    .base_zero (ra_is_zero && !in_update),
    .rev       (rev),
    .disp      (in_disp),
    .scaled    (kind_scaled_disp(kind)),
    .shamt     (in_shamt),
    .ea        (ea)
  );

  brld_data_fmt #(.XLEN(XLEN)) u_fmt (
    .tag (tag_q),
    .raw (mem_rsp_data),
    .val (fmt_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wb_en_q <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_REQ;
          addr_q  <= ea;
          tag_q   <= tag_d;
          wb_en_q <= in_update && !bad_form;
          inv_q   <= in_update && bad_form;
        end
        ST_REQ: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          data_q  <= fmt_val;
          state_q <= ST_OUT;
        end
        default: if (out_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready      = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_size  = tag_q.size_log;
  assign out_valid     = (state_q == ST_OUT);
  assign out_data      = data_q;
  assign out_wb_valid  = out_valid && wb_en_q;
  assign out_wb_data   = addr_q;
  assign out_invalid   = out_valid && inv_q;
endmodule

// File: rtl/brld_agu_chk.sv
module brld_agu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic [1:0]      mem_req_size,
  input logic            mem_rsp_valid,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_data,
  input logic            out_wb_valid,
  input logic [XLEN-1:0] out_wb_data,
  input logic            out_invalid
);
  logic [XLEN-1:0] issued_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) issued_addr <= '0;
    else if (mem_req_valid && mem_req_ready) issued_addr <= mem_req_addr;
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> mem_req_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req_valid && !out_valid);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size));

  assert_wb_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_wb_valid |-> out_wb_data == issued_addr);

  assert_invalid_nowb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> !out_wb_valid);

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_wb_valid) && $stable(out_invalid));

  assert_rsp_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(mem_rsp_valid) && !$past(mem_req_valid));
endmodule

bind brld_agu_top brld_agu_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .mem_rsp_valid (mem_rsp_valid),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_wb_valid  (out_wb_valid),
  .out_wb_data   (out_wb_data),
  .out_invalid   (out_invalid)
);

// File: tb/brld_agu_top_bench.sv
`timescale 1ns/1ps
module brld_agu_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_step = '0;
  logic [6:0]  in_vl = 7'd1;
  logic [63:0] in_base = '0;
  logic [4:0]  in_ra_idx = '0;
  logic [4:0]  in_rt_idx = '0;
  logic [15:0] in_disp = '0;
  logic [5:0]  in_shamt = '0;
  logic [2:0]  in_kind = '0;
  logic        in_update = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic        out_wb_valid;
  logic [63:0] out_wb_data;
  logic        out_invalid;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  brld_agu_top u_brld_agu_top (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] f_rev(logic [5:0] s, logic [6:0] vl);
    int k = 0;
    logic [5:0] r = '0;
    for (int i = 0; i < 7; i++) if (vl[i]) k = i;
    for (int i = 0; i < k; i++) r[k-1-i] = s[i];
    return r;
  endfunction

  function automatic logic [63:0] f_ea(logic [5:0] s, logic [6:0] vl,
      logic [63:0] b, logic [4:0] ra, logic upd, logic [15:0] d,
      logic [5:0] sh, logic [2:0] kind);
    logic signed [63:0] dv;
    logic [63:0] base;
    if (kind >= 3'd4) dv = 64'(signed'({d[13:0], 2'b00}));
    else dv = 64'(signed'(d));
    base = (!upd && ra == 0) ? 64'd0 : b;
    return base + ((64'(f_rev(s, vl)) * dv) << sh);
  endfunction

  function automatic logic [1:0] f_size(logic [2:0] kind);
    case (kind)
      3'd0: return 2'd0;
      3'd1, 3'd2: return 2'd1;
      3'd3, 3'd4: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [63:0] f_fmt(logic [2:0] kind, logic [63:0] r);
    case (kind)
      3'd0: return {56'd0, r[7:0]};
      3'd1: return {48'd0, r[15:0]};
      3'd2: return {{48{r[15]}}, r[15:0]};
      3'd3: return {32'd0, r[31:0]};
      3'd4: return {{32{r[31]}}, r[31:0]};
      default: return r;
    endcase
  endfunction

  task automatic run_op(logic [5:0] s, logic [6:0] vl, logic [63:0] b,
      logic [4:0] ra, logic [4:0] rt, logic [15:0] d, logic [5:0] sh,
      logic [2:0] kind, logic upd, logic [63:0] raw, string atag);
    logic [63:0] e_ea  = f_ea(s, vl, b, ra, upd, d, sh, kind);
    logic        e_bad = upd && (ra == 0 || ra == rt);
    logic        e_wb  = upd && !e_bad;
    logic [63:0] e_dat = f_fmt(kind, raw);
    string       dtag  = (kind == 0 || kind == 1 || kind == 3) ? "R8" : "R9";
    int          stall;
    in_step = s; in_vl = vl; in_base = b; in_ra_idx = ra; in_rt_idx = rt;
    in_disp = d; in_shamt = sh; in_kind = kind; in_update = upd;
    in_valid = 1'b1;
    chk("R1 in_ready idle", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 req after accept", 64'(mem_req_valid), 64'd1);
    // stray response while the request is still stalled
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b1; mem_rsp_data = ~raw;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R12 stray rsp ignored", 64'({mem_req_valid, out_valid}), 64'b10);
    chk({atag, " address"}, mem_req_addr, e_ea);
    chk("R7 size", 64'(mem_req_size), 64'(f_size(kind)));
    chk("R11 busy", 64'(in_ready), 64'd0);
    stall = $urandom % 3;
    repeat (stall) begin
      @(negedge clk);
      chk("R2 addr hold", mem_req_addr, e_ea);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R2 req drop", 64'(mem_req_valid), 64'd0);
    stall = $urandom % 3;
    repeat (stall) @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = raw;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
    chk("R12 out after rsp", 64'(out_valid), 64'd1);
    chk({dtag, " data"}, out_data, e_dat);
    chk(upd ? "R10 invalid flag" : "R4 invalid flag", 64'(out_invalid), 64'(e_bad));
    chk(e_bad ? "R10 wb suppressed" : "R5 wb flag", 64'(out_wb_valid), 64'(e_wb));
    if (e_wb) chk("R5 wb data", out_wb_data, e_ea);
    stall = $urandom % 3;
    repeat (stall) begin
      @(negedge clk);
      chk("R11 out hold", 64'({out_valid, in_ready}), 64'b10);
      chk("R11 data hold", out_data, e_dat);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R11 out consumed", 64'({out_valid, in_ready}), 64'b01);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0BAD_5EED));
    repeat (3) @(negedge clk);
    chk("R1 reset in_ready", 64'(in_ready), 64'd1);
    chk("R1 reset req", 64'(mem_req_valid), 64'd0);
    chk("R1 reset out", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: length one gives zero offset
    run_op(6'd5, 7'd1, 64'h1000, 5'd3, 5'd4, 16'h0040, 6'd0, 3'd3, 1'b0,
           64'h1122_3344_5566_7788, "R3");
    // R3: step 0x39 under length 8 -> low bits 001 -> rev 4
    run_op(6'h39, 7'd8, 64'h2000, 5'd3, 5'd4, 16'h0010, 6'd1, 3'd0, 1'b0,
           64'h0000_0000_0000_00F1, "R3");
    run_op(6'd1, 7'd64, 64'h0, 5'd3, 5'd4, 16'h0001, 6'd0, 3'd5, 1'b0,
           64'hDEAD_BEEF_0123_4567, "R3");
    // R4: base zero for non-update with register 0
    run_op(6'd3, 7'd4, 64'hFFFF_0000_0000_0000, 5'd0, 5'd4, 16'h0008, 6'd2,
           3'd1, 1'b0, 64'h0000_0000_0000_9ABC, "R4");
    // R5: update form uses base and writes back
    run_op(6'd2, 7'd4, 64'h0000_8000_0000_0000, 5'd3, 5'd7, 16'hFFF0, 6'd3,
           3'd2, 1'b1, 64'h0000_0000_0000_8001, "R5");
    // R6: scaled displacement, bits 15:14 discarded
    run_op(6'd1, 7'd2, 64'h4000, 5'd3, 5'd5, 16'h3FFF, 6'd0, 3'd4, 1'b0,
           64'h0000_0000_8000_0001, "R6");
    run_op(6'd1, 7'd2, 64'h4000, 5'd3, 5'd5, 16'hC005, 6'd0, 3'd5, 1'b0,
           64'hFEDC_BA98_7654_3210, "R6");
    run_op(6'd1, 7'd2, 64'h4000, 5'd3, 5'd5, 16'h8005, 6'd0, 3'd3, 1'b0,
           64'hFFFF_FFFF_FFFF_FFFF, "R6");
    // shift by 63 with negative displacement
    run_op(6'd1, 7'd2, 64'h1, 5'd3, 5'd5, 16'hFFFF, 6'd63, 3'd7, 1'b0,
           64'h8000_0000_0000_0000, "R2");
    // R10: illegal update forms
    run_op(6'd0, 7'd4, 64'h3000, 5'd0, 5'd9, 16'h0004, 6'd0, 3'd0, 1'b1,
           64'h0000_0000_0000_0080, "R10");
    run_op(6'd1, 7'd4, 64'h3000, 5'd9, 5'd9, 16'h0004, 6'd0, 3'd6, 1'b1,
           64'h8000_0000_0000_0080, "R10");
    for (int i = 0; i < 150; i++) begin
      logic [6:0] vl = 7'(1 << ($urandom % 7));
      run_op(6'($urandom), vl, {$urandom, $urandom}, 5'($urandom % 6),
             5'($urandom % 6), 16'($urandom), 6'($urandom), 3'($urandom),
             1'($urandom), {$urandom, $urandom}, "R2");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule